// File: doc/BRIEF.md
# Power Event Status and System Control Interrupt

This block holds the two 16-bit registers through which system software sees and controls power-management events, and it drives the level-sensitive system control interrupt (SCI) that reports them. Event sources outside the block (power button, sleep button, real-time-clock alarm, bus-master activity, wake, timer and global-lock status) report on dedicated inputs. Software reads and clears status, and programs the enable mask, over a simple single-cycle I/O bus. The status register sits at `BASE_ADDR` and the enable register at `BASE_ADDR + 2`. Both take only 16-bit accesses.

The bus side is a small state machine with three states. `BUS_IDLE` is the state with no response pending. `BUS_ACK` means a 16-bit access to one of the two registers was accepted. `BUS_REJECT` means an access of another size hit one of the two addresses. Every cycle, the request presented moves the machine to `BUS_ACK` or `BUS_REJECT`, and an idle cycle or an unmapped address moves it to `BUS_IDLE`. So each state lasts one cycle unless requests follow back to back. The interrupt side has two states. `SCI_LOW` moves to `SCI_HIGH` when some enabled source is pending (transition *raise*). `SCI_HIGH` moves back to `SCI_LOW` when none is pending (transition *drop*). The output therefore changes only when the computed need differs from its present level.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status register and the enable register both read 0x0000, and `sci` is low.
- R2: A write to the enable register stores only bit 8 (power-button enable) and bit 5 (global-lock enable). Every other enable bit reads back as 0.
- R3: Status bits 4 (bus master), 8 (power button), 9 (sleep button), 10 (RTC) and 15 (wake) are set by a one-cycle high on their event input. Once set they stay set until a status write has a 1 in that position. Writing 0 to them has no effect.
- R4: Status bit 0 (timer) and bit 5 (global lock) show the level of their inputs one cycle later. Status writes never change them. The other status bits read 0.
- R5: `sci` is high one cycle after any of bits 0, 5, 8, 9 or 10 has both its status bit and its enable bit set. It is low one cycle after no such pair exists. Bits 4 and 15 never raise it.
- R6: A power-button event is ignored while `sci_en` is low.
- R7: When a power-button event and a status write clearing bit 8 fall in the same cycle, the event wins and bit 8 stays set.
- R8: An access to either register with `io_bytes` other than 2 gets `io_err` one cycle later, with no `io_ack`, and changes no register.
- R9: A 16-bit access to a register gets `io_ack` one cycle later. A read returns the register value from before that cycle's update, and a write returns 0 on `io_rdata`. An access to any other address gets neither `io_ack` nor `io_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_sel | input | 1 | Bus request valid this cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | ADDR_W | Byte address of the access |
| io_bytes | input | 3 | Access size in bytes |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, valid with io_ack |
| io_ack | output | 1 | Access accepted, one cycle after the request |
| io_err | output | 1 | Access rejected for size, one cycle after the request |
| sci_en | input | 1 | SCI mode enable from the control block; gates power-button events |
| evt_tmr | input | 1 | Timer status level |
| evt_gbl | input | 1 | Global-lock status level |
| evt_bm | input | 1 | Bus-master event pulse |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_slpbtn | input | 1 | Sleep-button event pulse |
| evt_rtc | input | 1 | RTC alarm event pulse |
| evt_wak | input | 1 | Wake event pulse |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
A bus response (`io_ack`, `io_err`, `io_rdata`) is due one cycle after its request. So each access puts an expected item on a queue, stamped with the cycle count at which it falls due. A monitor on the falling edge compares the item in exactly that cycle, including the silent case for unmapped addresses. Status and enable registers update at the request or event edge, and `sci` follows one edge later. The bench therefore samples `sci` no earlier than two falling edges after an event or level change, and one falling edge after a write task returns. An event that falls in the same cycle as a clearing write is driven inside the bus task, so both land on the same edge.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int REG_W = 16;

    localparam int BIT_TMR = 0;
    localparam int BIT_BM  = 4;
    localparam int BIT_GBL = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_SLP = 9;
    localparam int BIT_RTC = 10;
    localparam int BIT_WAK = 15;

    // latched, write-1-to-clear status positions
    localparam logic [REG_W-1:0] W1C_MASK =
        REG_W'((1 << BIT_WAK) | (1 << BIT_RTC) | (1 << BIT_SLP) |
               (1 << BIT_PWR) | (1 << BIT_BM));
    // status positions that mirror an input level
    localparam logic [REG_W-1:0] LEVEL_MASK =
        REG_W'((1 << BIT_TMR) | (1 << BIT_GBL));
    // enable positions that hold a written value
    localparam logic [REG_W-1:0] EN_WR_MASK =
        REG_W'((1 << BIT_PWR) | (1 << BIT_GBL));
    // status/enable pairs that can raise the interrupt
    localparam logic [REG_W-1:0] SCI_SRC_MASK =
        REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) |
               (1 << BIT_SLP) | (1 << BIT_RTC));

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_ACK    = 2'd1,
        BUS_REJECT = 2'd2
    } bus_state_e;

    typedef enum logic {
        SCI_LOW  = 1'b0,
        SCI_HIGH = 1'b1
    } sci_state_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_STAT = 2'd1,
        SEL_EN   = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/pm_bus_fsm.sv
module pm_bus_fsm
    import pm_evt_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [2:0]        io_bytes,
    input  logic [REG_W-1:0]  stat_q,
    input  logic [REG_W-1:0]  en_q,
    output logic              stat_wr,
    output logic              en_wr,
    output logic [REG_W-1:0]  io_rdata,
    output logic              io_ack,
    output logic              io_err
);

    localparam int                ACC_BYTES = REG_W / 8;
    localparam logic [ADDR_W-1:0] EN_ADDR   = ADDR_W'(BASE_ADDR + ACC_BYTES);

    bus_state_e        state_q, state_d;
    reg_sel_e          sel;
    logic              size_ok;
    logic [REG_W-1:0]  rdata_q, rdata_d;

    always_comb begin
        if (io_addr == BASE_ADDR)     sel = SEL_STAT;
        else if (io_addr == EN_ADDR)  sel = SEL_EN;
        else                          sel = SEL_NONE;
    end

    assign size_ok = (io_bytes == 3'(ACC_BYTES));

    // next state and captured read data
    always_comb begin
        state_d = BUS_IDLE;
        rdata_d = '0;
        if (io_sel && sel != SEL_NONE) begin
            if (size_ok) begin
                state_d = BUS_ACK;
                if (!io_wr) begin
                    rdata_d = (sel == SEL_STAT) ? stat_q : en_q;
                end
            end else begin
                state_d = BUS_REJECT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    // outputs
    always_comb begin
        io_ack   = 1'b0;
        io_err   = 1'b0;
        io_rdata = '0;
        unique case (state_q)
            BUS_IDLE: ;
            BUS_ACK: begin
                io_ack   = 1'b1;
                io_rdata = rdata_q;
            end
            BUS_REJECT: io_err = 1'b1;
            default: ;
        endcase
    end

    assign stat_wr = io_sel && io_wr && size_ok && (sel == SEL_STAT);
    assign en_wr   = io_sel && io_wr && size_ok && (sel == SEL_EN);

    assert_reject_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && (io_addr == BASE_ADDR || io_addr == EN_ADDR) && io_bytes != 3'd2)
        |=> (io_err && !io_ack));

    assert_ack_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_ack && io_err));

    assert_miss_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_addr != BASE_ADDR && io_addr != EN_ADDR) |=> (!io_ack && !io_err));

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_wr,
    input  logic             en_wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             sci_en,
    input  logic             evt_tmr,
    input  logic             evt_gbl,
    input  logic             evt_bm,
    input  logic             evt_pwrbtn,
    input  logic             evt_slpbtn,
    input  logic             evt_rtc,
    input  logic             evt_wak,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] en_q
);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] lvl_vec;
    logic             unused_wbits;

    assign unused_wbits = ^(wdata & ~(W1C_MASK | EN_WR_MASK));

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_BM]  = evt_bm;
        set_vec[BIT_PWR] = evt_pwrbtn && sci_en;
        set_vec[BIT_SLP] = evt_slpbtn;
        set_vec[BIT_RTC] = evt_rtc;
        set_vec[BIT_WAK] = evt_wak;
        lvl_vec          = '0;
        lvl_vec[BIT_TMR] = evt_tmr;
        lvl_vec[BIT_GBL] = evt_gbl;
    end

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (W1C_MASK[i]) begin : g_latch
            logic b_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  b_q <= 1'b0;
                else if (set_vec[i])         b_q <= 1'b1;
                else if (stat_wr && wdata[i]) b_q <= 1'b0;
            end
            assign stat_q[i] = b_q;
        end else if (LEVEL_MASK[i]) begin : g_level
            logic b_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) b_q <= 1'b0;
                else        b_q <= lvl_vec[i];
            end
            assign stat_q[i] = b_q;
        end else begin : g_rsvd
            assign stat_q[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata & EN_WR_MASK;
    end

    assert_pwr_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pwrbtn && sci_en) |=> stat_q[BIT_PWR]);

    assert_pwr_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sci_en && !stat_q[BIT_PWR]) |=> !stat_q[BIT_PWR]);

    assert_tmr_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_tmr |=> stat_q[BIT_TMR]);

    assert_gbl_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_gbl |=> !stat_q[BIT_GBL]);

    assert_wr0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wdata[BIT_RTC] && stat_q[BIT_RTC]) |=> stat_q[BIT_RTC]);

endmodule

// File: rtl/pm_sci_fsm.sv
module pm_sci_fsm
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat_q,
    input  logic [REG_W-1:0] en_q,
    output logic             sci
);

    sci_state_e state_q, state_d;
    logic       need;
    logic       unused_bits;

    assign need        = |(stat_q & en_q & SCI_SRC_MASK);
    assign unused_bits = ^((stat_q | en_q) & ~SCI_SRC_MASK);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCI_LOW:  if (need)  state_d = SCI_HIGH;   // raise
            SCI_HIGH: if (!need) state_d = SCI_LOW;    // drop
            default:  state_d = SCI_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCI_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SCI_HIGH: sci = 1'b1;
            default:  sci = 1'b0;
        endcase
    end

    assert_sci_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sci) |-> $past(|(stat_q & en_q)));

    assert_sci_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sci) |-> !$past(stat_q[BIT_PWR] && en_q[BIT_PWR]));

    assert_sci_ignores_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == '0) |=> !sci);

endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
    import pm_evt_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [2:0]        io_bytes,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    output logic              io_ack,
    output logic              io_err,
    input  logic              sci_en,
    input  logic              evt_tmr,
    input  logic              evt_gbl,
    input  logic              evt_bm,
    input  logic              evt_pwrbtn,
    input  logic              evt_slpbtn,
    input  logic              evt_rtc,
    input  logic              evt_wak,
    output logic              sci
);

    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] en_q;
    logic             stat_wr;
    logic             en_wr;

    pm_bus_fsm #(
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_sel  (io_sel),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_bytes(io_bytes),
        .stat_q  (stat_q),
        .en_q    (en_q),
        .stat_wr (stat_wr),
        .en_wr   (en_wr),
        .io_rdata(io_rdata),
        .io_ack  (io_ack),
        .io_err  (io_err)
    );

    pm_evt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_wr   (stat_wr),
        .en_wr     (en_wr),
        .wdata     (io_wdata),
        .sci_en    (sci_en),
        .evt_tmr   (evt_tmr),
        .evt_gbl   (evt_gbl),
        .evt_bm    (evt_bm),
        .evt_pwrbtn(evt_pwrbtn),
        .evt_slpbtn(evt_slpbtn),
        .evt_rtc   (evt_rtc),
        .evt_wak   (evt_wak),
        .stat_q    (stat_q),
        .en_q      (en_q)
    );

    pm_sci_fsm u_sci (
        .clk   (clk),
        .rst_n (rst_n),
        .stat_q(stat_q),
        .en_q  (en_q),
        .sci   (sci)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sci);

endmodule

// File: tb/pm_event_sci_bench.sv
module pm_event_sci_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0, io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [2:0]  io_bytes = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        io_ack, io_err;
    logic        sci_en = 1'b0;
    logic        evt_tmr = 1'b0, evt_gbl = 1'b0, evt_bm = 1'b0, evt_pwrbtn = 1'b0;
    logic        evt_slpbtn = 1'b0, evt_rtc = 1'b0, evt_wak = 1'b0;
    logic        sci;

    localparam logic [15:0] A_STAT = 16'h0400;
    localparam logic [15:0] A_EN   = 16'h0402;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int          due;
        bit          ack;
        bit          err;
        logic [15:0] data;
        string       tag;
    } resp_t;
    resp_t sb_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pm_event_sci u_pm_event_sci (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr),
        .io_addr(io_addr), .io_bytes(io_bytes), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_ack(io_ack), .io_err(io_err),
        .sci_en(sci_en), .evt_tmr(evt_tmr), .evt_gbl(evt_gbl), .evt_bm(evt_bm),
        .evt_pwrbtn(evt_pwrbtn), .evt_slpbtn(evt_slpbtn), .evt_rtc(evt_rtc),
        .evt_wak(evt_wak), .sci(sci)
    );

    // monitor: compare each expected response in the cycle it falls due
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
                resp_t e;
                e = sb_q.pop_front();
                checks++;
                if (io_ack !== e.ack || io_err !== e.err || io_rdata !== e.data) begin
                    errors++;
                    $display("FAIL %s: ack=%0b err=%0b data=%h expected ack=%0b err=%0b data=%h",
                             e.tag, io_ack, io_err, io_rdata, e.ack, e.err, e.data);
                end
            end else if (io_ack || io_err) begin
                checks++;
                errors++;
                $display("FAIL R9 unexpected response: ack=%0b err=%0b expected none", io_ack, io_err);
            end
        end
    end

    task automatic bus(input bit wr, input logic [15:0] addr, input logic [2:0] nb,
                       input logic [15:0] wd, input bit eack, input bit eerr,
                       input logic [15:0] edata, input string tag, input bit with_pwr = 0);
        resp_t e;
        @(negedge clk);
        io_sel = 1'b1; io_wr = wr; io_addr = addr; io_bytes = nb; io_wdata = wd;
        evt_pwrbtn = with_pwr;
        e.due = cyc + 1; e.ack = eack; e.err = eerr; e.data = edata; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0; evt_pwrbtn = 1'b0;
    endtask

    task automatic rd(input logic [15:0] addr, input logic [15:0] exp, input string tag);
        bus(1'b0, addr, 3'd2, 16'h0, 1'b1, 1'b0, exp, tag);
    endtask

    task automatic wr(input logic [15:0] addr, input logic [15:0] d, input string tag);
        bus(1'b1, addr, 3'd2, d, 1'b1, 1'b0, 16'h0, tag);
    endtask

    task automatic pulse(input bit p, input bit s, input bit r, input bit b, input bit w);
        @(negedge clk);
        evt_pwrbtn = p; evt_slpbtn = s; evt_rtc = r; evt_bm = b; evt_wak = w;
        @(negedge clk);
        evt_pwrbtn = 0; evt_slpbtn = 0; evt_rtc = 0; evt_bm = 0; evt_wak = 0;
        @(negedge clk);
    endtask

    task automatic chk_sci(input bit exp, input string tag);
        checks++;
        if (sci !== exp) begin
            errors++;
            $display("FAIL %s: sci=%0b expected %0b", tag, sci, exp);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_sci(1'b0, "R1 sci after reset");
        rd(A_STAT, 16'h0000, "R1 status after reset");
        rd(A_EN,   16'h0000, "R1 enable after reset");

        wr(A_EN, 16'hFFFF, "R9 write ack");
        rd(A_EN, 16'h0120, "R2 only bits 8 and 5 stored");

        pulse(1, 0, 0, 0, 0);
        rd(A_STAT, 16'h0000, "R6 power button ignored with sci_en low");
        chk_sci(1'b0, "R6 sci stays low");

        sci_en = 1'b1;
        pulse(1, 0, 0, 0, 0);
        chk_sci(1'b1, "R5 sci raised by power button");
        rd(A_STAT, 16'h0100, "R3 power button latched");
        pulse(1, 0, 0, 0, 0);
        rd(A_STAT, 16'h0100, "R3 repeat event keeps bit");
        wr(A_STAT, 16'h0000, "R3 write zero");
        rd(A_STAT, 16'h0100, "R3 writing 0 has no effect");
        wr(A_STAT, 16'h0100, "R3 clear write");
        @(negedge clk);
        chk_sci(1'b0, "R5 sci dropped after clear");
        rd(A_STAT, 16'h0000, "R3 bit 8 cleared by writing 1");

        pulse(0, 1, 1, 1, 1);
        chk_sci(1'b0, "R5 unenabled sources do not raise sci");
        rd(A_STAT, 16'h8610, "R3 bits 15 10 9 4 latched");
        wr(A_STAT, 16'hFFFF, "R3 clear all");
        rd(A_STAT, 16'h0000, "R3 all latched bits cleared");

        @(negedge clk); evt_tmr = 1'b1; evt_gbl = 1'b1;
        @(negedge clk); @(negedge clk);
        chk_sci(1'b1, "R5 sci raised by global-lock level");
        rd(A_STAT, 16'h0021, "R4 level bits shown");
        wr(A_STAT, 16'hFFFF, "R4 write ones");
        rd(A_STAT, 16'h0021, "R4 level bits unaffected by write");
        @(negedge clk); evt_gbl = 1'b0;
        @(negedge clk); @(negedge clk);
        chk_sci(1'b0, "R5 timer without stored enable does not raise sci");
        rd(A_STAT, 16'h0001, "R4 global bit follows input low");
        @(negedge clk); evt_tmr = 1'b0;
        @(negedge clk);
        rd(A_STAT, 16'h0000, "R4 timer bit follows input low");

        pulse(1, 0, 0, 0, 0);
        bus(1'b1, A_STAT, 3'd2, 16'h0100, 1'b1, 1'b0, 16'h0, "R7 clear with event", 1'b1);
        rd(A_STAT, 16'h0100, "R7 event wins over clear");
        wr(A_STAT, 16'h0100, "R7 plain clear");
        rd(A_STAT, 16'h0000, "R7 plain clear works");

        bus(1'b1, A_EN, 3'd1, 16'h0000, 1'b0, 1'b1, 16'h0, "R8 byte write rejected");
        rd(A_EN, 16'h0120, "R8 enable unchanged after rejected write");
        bus(1'b0, A_STAT, 3'd4, 16'h0000, 1'b0, 1'b1, 16'h0, "R8 dword read rejected");
        pulse(1, 0, 0, 0, 0);
        bus(1'b1, A_STAT, 3'd1, 16'h0100, 1'b0, 1'b1, 16'h0, "R8 byte clear rejected");
        rd(A_STAT, 16'h0100, "R8 status unchanged after rejected write");

        bus(1'b1, 16'h0404, 3'd2, 16'hFFFF, 1'b0, 1'b0, 16'h0, "R9 unmapped write silent");
        bus(1'b0, 16'h0401, 3'd2, 16'h0000, 1'b0, 1'b0, 16'h0, "R9 unmapped read silent");
        rd(A_STAT, 16'h0100, "R9 status unchanged by unmapped write");

        chk_sci(1'b1, "R5 sci high with power button pending");
        wr(A_EN, 16'h0000, "R2 disable");
        @(negedge clk);
        chk_sci(1'b0, "R5 sci dropped by enable clear");
        rd(A_EN, 16'h0000, "R2 enable reads zero");
        wr(A_EN, 16'h0100, "R2 re-enable");
        @(negedge clk);
        chk_sci(1'b1, "R5 sci raised by enable set");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            if (sb_q.size() != 0) begin
                checks++;
                errors++;
                $display("FAIL R9 responses missing: %0d pending expected 0", sb_q.size());
            end
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule